// File: doc/BRIEF.md
# Priority Interrupt Controller with Level Stack

This block takes one request line from each of many interrupt sources and selects a winner. Each source has a programmable priority. The block raises a single request to the processor and supplies the number of the winning source as its vector. A current-level register sets the bar that a source has to clear. When a request is acknowledged, the old level is saved on a push-down stack of levels and the winner's priority becomes the new level. An end-of-interrupt write takes the saved level back off the stack.

Once a request has been captured, it is frozen until it is acknowledged. It stays frozen even if its source goes away or a more urgent source shows up. The vector can be taken in one of two ways:
- In software mode, a read of an acknowledge register returns the vector.
- In hardware mode, the processor reads the vector pins and pulses an acknowledge line.

Per-source enables, masks and flags are assumed to be merged into the one request line of each source upstream. Dropping that line is the same as clearing the flag, and raising it again is the same as a new event. Register addresses are word addresses on a simple single-cycle bus:
- 0x00: mode (bit 0 = hardware mode).
- 0x01: current level.
- 0x02: acknowledge.
- 0x03: end of interrupt.
- 0x10+i: priority of source i.

Top module: `prio_intc`

## Requirements
- R1: A source may be captured only when its request is high and its priority is strictly greater than the current level. A source with priority 0 is never captured.
- R2: Among the eligible sources, the one with the highest priority wins. On a tie, the lowest source number wins. `irq_vec` carries the source number, and `irq_req` rises one clock edge after the request is applied.
- R3: While `irq_req` is high, the vector and the captured priority stay frozen. A later request of higher priority does not replace them, and neither does the source dropping its request.
- R4: On an acknowledge, `irq_req` is low after that edge and the current level takes the captured priority. The previous level is pushed onto the stack. The next capture can happen at the following edge.
- R5: In software mode (mode bit 0 = 0), a bus read of address 0x02 returns the vector in the low bits and acknowledges a pending request. In hardware mode, the same read returns the vector but does not acknowledge.
- R6: In hardware mode, `irq_ack` high while `irq_req` is high acknowledges the request. In software mode, `irq_ack` is ignored.
- R7: A bus write to address 0x03 pops the stack into the current level. A pop of an empty stack sets the level to 0.
- R8: A bus write to address 0x01 loads bits [3:0] into the current level. Pending requests at or below that level are then blocked.
- R9: A hardware acknowledge and an end-of-interrupt write can land in the same cycle. In that case the level popped by the end of interrupt is saved in place of the old level, the stack depth is unchanged, and the current level takes the captured priority.
- R10: After reset, `irq_req` is 0, the current level is 0, software mode is selected, and all priorities are 0.
- R11: A write to address 0x10+i sets the priority of source i from bits [3:0]. A read of that address returns it zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | NUM_SRC | Combined request line per source |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the strobe cycle |
| irq_req | output | 1 | Registered request to the processor |
| irq_vec | output | VEC_W | Vector of the captured source |
| irq_ack | input | 1 | Hardware-mode acknowledge |

## Verification
Only in hardware mode can an acknowledge and an end-of-interrupt write fall in the same cycle, because the acknowledge then arrives on a pin rather than through the bus. The bench first nests two handlers so that the stack holds two different levels. It then raises a third, higher source and drives `irq_ack` together with an end-of-interrupt write. It judges the result from the level read back afterwards and from the levels restored by the two end-of-interrupt writes that follow, which exposes any design that saves the wrong level or loses a stack entry.

// File: rtl/intc_pkg.sv
// Shared constants for the priority interrupt controller.
// Assumes a word-addressed register bus; offsets are small integers
// that the top module casts to its address width.
package intc_pkg;
    localparam int unsigned REG_MODE      = 0;
    localparam int unsigned REG_CURPRI    = 1;
    localparam int unsigned REG_ACK       = 2;
    localparam int unsigned REG_EOI       = 3;
    localparam int unsigned REG_PRIO_BASE = 16;
endpackage

// File: rtl/intc_prio_regs.sv
// Priority register file: one PRIO_W-bit register per source.
// Assumes the caller qualifies wr_en with a bus write strobe; the
// address decode for each source is generated here.
module intc_prio_regs #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PRIO_W  = 4,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [PRIO_W-1:0]              wdata,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio
);
    import intc_pkg::*;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic hit;
        assign hit = wr_en && (addr == ADDR_W'(REG_PRIO_BASE + g));

        // Hold the programmed priority of source g.
        always_ff @(posedge clk) begin
            if (!rst_n)   prio[g] <= '0;
            else if (hit) prio[g] <= wdata;
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
// Combinational winner search across all sources.
// A source qualifies when its request is high and its priority is
// strictly above the current level; ties go to the lowest index.
// Assumes at most a few dozen sources (linear scan depth).
module intc_arbiter #(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned PRIO_W  = 4,
    localparam int unsigned VEC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             req,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]              cur_prio,
    output logic                           found,
    output logic [VEC_W-1:0]               win_id,
    output logic [PRIO_W-1:0]              win_prio
);
    // Scan upward, replacing only on a strictly higher priority.
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = cur_prio;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && (prio[i] > win_prio)) begin
                found    = 1'b1;
                win_id   = VEC_W'(i);
                win_prio = prio[i];
            end
        end
    end

    // R1: a reported winner is a live request above the current level.
    always_ff @(posedge clk) begin
        if (rst_n && found) begin
            p_win_live_r1: assert (req[win_id] && (prio[win_id] > cur_prio))
                else $error("arbiter winner not eligible");
        end
    end
endmodule

// File: rtl/intc_prio_lifo.sv
// Push-down stack of saved priority levels.
// A pop of an empty stack yields 0. A push when full is dropped.
// A push and a pop together rewrite the top entry (or create one
// when empty), so the depth is unchanged except from empty.
module intc_prio_lifo #(
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned PRIO_W = 4,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_data,
    output logic [PRIO_W-1:0] pop_data
);
    logic [PRIO_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  count;
    logic              empty;
    logic              full;
    logic [IDX_W-1:0]  top_idx;
    logic [IDX_W-1:0]  wr_idx;

    assign empty    = (count == '0);
    assign full     = (count == CNT_W'(DEPTH));
    assign top_idx  = IDX_W'(count - CNT_W'(1));
    assign wr_idx   = IDX_W'(count);
    assign pop_data = empty ? '0 : mem[top_idx];

    // Update depth counter and stored levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            unique case ({push, pop})
                2'b10: if (!full) begin
                    mem[wr_idx] <= push_data;
                    count       <= count + CNT_W'(1);
                end
                2'b01: if (!empty) count <= count - CNT_W'(1);
                2'b11: if (empty) begin
                    mem[0] <= push_data;
                    count  <= CNT_W'(1);
                end else begin
                    mem[top_idx] <= push_data;
                end
                default: ;
            endcase
        end
    end

    // R4: a lone push below full deepens the stack by one.
    p_push_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (count == $past(count) + CNT_W'(1)));

    // R7: a lone pop on an empty stack leaves it empty.
    p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> (count == '0));

    // R9: push with pop on a non-empty stack keeps the depth.
    p_swap_depth_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty) |=> (count == $past(count)));

    // Depth never exceeds the storage.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/prio_intc.sv
// Priority interrupt controller top.
// Decodes the register bus, holds the mode bit and the current
// level, and owns the capture register that drives irq_req/irq_vec.
// A capture is frozen until acknowledged (no spurious vector).
// Assumes one bus access per cycle and a request input per source
// that already merges flag, enable and mask.
module prio_intc #(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned PRIO_W      = 4,
    parameter int unsigned STACK_DEPTH = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    localparam int unsigned VEC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    input  logic               irq_ack
);
    import intc_pkg::*;

    logic                           mode_hw;
    logic [PRIO_W-1:0]              cur_prio;
    logic [PRIO_W-1:0]              cap_prio;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic                           found;
    logic [VEC_W-1:0]               win_id;
    logic [PRIO_W-1:0]              win_prio;
    logic [PRIO_W-1:0]              pop_data;
    logic [PRIO_W-1:0]              push_data;
    logic                           wr_strobe;
    logic                           rd_strobe;
    logic                           wr_mode;
    logic                           wr_cur;
    logic                           eoi;
    logic                           ack;
    logic                           unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:PRIO_W];

    // Bus strobe decode.
    assign wr_strobe = bus_sel && bus_wr;
    assign rd_strobe = bus_sel && !bus_wr;
    assign wr_mode   = wr_strobe && (bus_addr == ADDR_W'(REG_MODE));
    assign wr_cur    = wr_strobe && (bus_addr == ADDR_W'(REG_CURPRI));
    assign eoi       = wr_strobe && (bus_addr == ADDR_W'(REG_EOI));

    // Acknowledge source depends on the vector mode.
    always_comb begin
        if (mode_hw) ack = irq_req && irq_ack;
        else         ack = irq_req && rd_strobe && (bus_addr == ADDR_W'(REG_ACK));
    end

    // Level saved on acknowledge: the one left after a same-cycle pop.
    assign push_data = eoi ? pop_data : cur_prio;

    intc_prio_regs #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_strobe),
        .addr  (bus_addr),
        .wdata (bus_wdata[PRIO_W-1:0]),
        .prio  (prio)
    );

    intc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (src_req),
        .prio     (prio),
        .cur_prio (cur_prio),
        .found    (found),
        .win_id   (win_id),
        .win_prio (win_prio)
    );

    intc_prio_lifo #(
        .DEPTH  (STACK_DEPTH),
        .PRIO_W (PRIO_W)
    ) u_lifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack),
        .pop       (eoi),
        .push_data (push_data),
        .pop_data  (pop_data)
    );

    // Mode bit: 0 = software vector, 1 = hardware vector.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_hw <= 1'b0;
        else if (wr_mode) mode_hw <= bus_wdata[0];
    end

    // Current level: acknowledge wins over pop, pop over direct write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_prio <= '0;
        else if (ack)    cur_prio <= cap_prio;
        else if (eoi)    cur_prio <= pop_data;
        else if (wr_cur) cur_prio <= bus_wdata[PRIO_W-1:0];
    end

    // Capture register: latch a winner, hold it until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req  <= 1'b0;
            irq_vec  <= '0;
            cap_prio <= '0;
        end else if (ack) begin
            irq_req  <= 1'b0;
        end else if (!irq_req && found) begin
            irq_req  <= 1'b1;
            irq_vec  <= win_id;
            cap_prio <= win_prio;
        end
    end

    // Read data mux, valid in the strobe cycle.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_MODE))        bus_rdata = DATA_W'(mode_hw);
        else if (bus_addr == ADDR_W'(REG_CURPRI)) bus_rdata = DATA_W'(cur_prio);
        else if (bus_addr == ADDR_W'(REG_ACK))    bus_rdata = DATA_W'(irq_vec);
        else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (bus_addr == ADDR_W'(REG_PRIO_BASE + i)) bus_rdata = DATA_W'(prio[i]);
            end
        end
    end

    // R3: a held request keeps its vector until acknowledged.
    p_hold_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !ack) |=> (irq_req && $stable(irq_vec) && $stable(cap_prio)));

    // R4: acknowledge drops the request at the next edge.
    p_ack_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq_req);

    // R4: acknowledge loads the captured priority as the level.
    p_ack_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (cur_prio == $past(cap_prio)));

    // R1: a new capture lies strictly above the level it was judged against.
    p_capture_above_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (cap_prio > $past(cur_prio)));

    // R7: a lone end of interrupt restores the popped level.
    p_eoi_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !ack) |=> (cur_prio == $past(pop_data)));

    // R6: in software mode the pin acknowledge alone changes nothing.
    p_pin_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_hw && irq_req && irq_ack && !rd_strobe) |=> irq_req);
endmodule

// File: tb/prio_intc_tb.sv
// Self-checking bench: directed corner cases plus seeded random rounds.
module prio_intc_tb_top;
    localparam int NUM_SRC = 32;
    localparam int A_MODE = 0, A_CUR = 1, A_ACK = 2, A_EOI = 3, A_PRIO = 16;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_SRC-1:0] src_req;
    logic               bus_sel;
    logic               bus_wr;
    logic [7:0]         bus_addr;
    logic [31:0]        bus_wdata;
    logic [31:0]        bus_rdata;
    logic               irq_req;
    logic [4:0]         irq_vec;
    logic               irq_ack;

    int checks = 0;
    int failures = 0;
    int m_prio [NUM_SRC];

    prio_intc dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input int a, input int d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 32'(d);
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output int d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'(a);
        #1 d = int'(bus_rdata);
        tick();
        bus_sel = 1'b0;
    endtask

    task automatic set_prio(input int s, input int p);
        reg_write(A_PRIO + s, p);
        m_prio[s] = p;
    endtask

    task automatic check_level(input string tag, input int exp);
        int v;
        reg_read(A_CUR, v);
        check(v == exp, tag, v, exp);
    endtask

    // Expected winner from the requirements: -1 when none qualifies.
    function automatic int model_win(input logic [NUM_SRC-1:0] req, input int cur);
        int best = cur;
        int id = -1;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req[i] && m_prio[i] > best) begin
                best = m_prio[i];
                id = i;
            end
        end
        return id;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v;
        int unsigned seed_init;
        seed_init = $urandom(32'd1234);
        rst_n = 1'b0; src_req = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0; irq_ack = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) m_prio[i] = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R10: reset state.
        check(irq_req == 1'b0, "R10 irq_req", int'(irq_req), 0);
        reg_read(A_MODE, v);  check(v == 0, "R10 mode", v, 0);
        check_level("R10 level", 0);
        reg_read(A_PRIO + 5, v); check(v == 0, "R10 prio5", v, 0);

        // R11: priority write and readback.
        set_prio(3, 5); set_prio(7, 9); set_prio(12, 9);
        reg_read(A_PRIO + 7, v); check(v == 9, "R11 prio7", v, 9);

        // R1: priority 0 never captured.
        src_req = 32'(1) << 20;
        tick(); tick();
        check(irq_req == 1'b0, "R1 prio0 blocked", int'(irq_req), 0);
        src_req = '0;

        // R2/R3: capture, then freeze against higher request and drop.
        src_req = 32'(1) << 3;
        tick();
        check(irq_req == 1'b1 && irq_vec == 3, "R2 capture src3", int'(irq_vec), 3);
        src_req = (32'(1) << 3) | (32'(1) << 7);
        tick();
        check(irq_vec == 3, "R3 higher ignored", int'(irq_vec), 3);
        src_req = 32'(1) << 7;
        tick();
        check(irq_req == 1'b1 && irq_vec == 3, "R3 held after drop", int'(irq_vec), 3);

        // R5/R4: software acknowledge, then next capture.
        reg_read(A_ACK, v);
        check(v == 3, "R5 ack vector", v, 3);
        check(irq_req == 1'b0, "R4 req drops", int'(irq_req), 0);
        tick();
        check(irq_req == 1'b1 && irq_vec == 7, "R4 next capture", int'(irq_vec), 7);
        check_level("R4 level after ack", 5);
        reg_read(A_ACK, v);
        src_req = '0;
        check_level("R4 nested level", 9);

        // R7: pops restore, empty pop gives 0.
        reg_write(A_EOI, 0); check_level("R7 pop to 5", 5);
        reg_write(A_EOI, 0); check_level("R7 pop to 0", 0);
        reg_write(A_CUR, 6);
        reg_write(A_EOI, 0); check_level("R7 empty pop", 0);

        // R2: equal priority tie goes to the lowest index.
        src_req = (32'(1) << 12) | (32'(1) << 7);
        tick();
        check(irq_vec == 7, "R2 tie lowest", int'(irq_vec), 7);
        reg_read(A_ACK, v);
        src_req = '0;
        reg_write(A_EOI, 0);

        // R8: level write blocks equal priority, admits higher.
        reg_write(A_CUR, 9);
        src_req = 32'(1) << 7;
        tick(); tick();
        check(irq_req == 1'b0, "R8 equal blocked", int'(irq_req), 0);
        set_prio(3, 10);
        src_req = 32'(1) << 3;
        tick();
        check(irq_req == 1'b1 && irq_vec == 3, "R8 higher passes", int'(irq_vec), 3);

        // R6: pin acknowledge ignored in software mode.
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        check(irq_req == 1'b1, "R6 pin ignored sw", int'(irq_req), 1);
        reg_read(A_ACK, v);
        src_req = '0;
        reg_write(A_EOI, 0);
        check_level("R8 level restored", 9);
        reg_write(A_CUR, 0);

        // R6/R5: hardware mode.
        reg_write(A_MODE, 1);
        src_req = 32'(1) << 3;
        tick();
        reg_read(A_ACK, v);
        check(v == 3 && irq_req == 1'b1, "R5 hw read no ack", int'(irq_req), 1);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        src_req = '0;
        check(irq_req == 1'b0, "R6 hw ack", int'(irq_req), 0);
        check_level("R6 hw level", 10);

        // R9: nest once more, then ack and EOI in the same cycle.
        set_prio(20, 12);
        src_req = 32'(1) << 20;
        tick();
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        src_req = '0;
        check_level("R9 setup level", 12);
        set_prio(12, 14);
        src_req = 32'(1) << 12;
        tick();
        check(irq_vec == 12, "R9 capture", int'(irq_vec), 12);
        irq_ack = 1'b1;
        reg_write(A_EOI, 0);
        irq_ack = 1'b0;
        src_req = '0;
        check_level("R9 level is captured", 14);
        reg_write(A_EOI, 0); check_level("R9 saved level", 10);
        reg_write(A_EOI, 0); check_level("R9 bottom level", 0);

        // Random rounds in software mode (R1, R2, R4, R7).
        reg_write(A_MODE, 0);
        for (int r = 0; r < 40; r++) begin
            int cur;
            int w;
            logic [NUM_SRC-1:0] req;
            for (int s = 0; s < NUM_SRC; s++) set_prio(s, int'($urandom % 16));
            cur = int'($urandom % 15);
            reg_write(A_CUR, cur);
            req = NUM_SRC'($urandom & $urandom);
            w = model_win(req, cur);
            src_req = req;
            tick();
            if (w >= 0) begin
                check(irq_req == 1'b1 && irq_vec == 5'(w), "R2 random winner", int'(irq_vec), w);
                reg_read(A_ACK, v);
                src_req = '0;
                check(v == w, "R5 random ack vector", v, w);
                check_level("R4 random level", m_prio[w]);
                reg_write(A_EOI, 0);
                check_level("R7 random restore", cur);
            end else begin
                check(irq_req == 1'b0, "R1 random none", int'(irq_req), 0);
                src_req = '0;
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule